// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block models the management register space of an Ethernet PHY as a management controller sees it. Thirty-two 16-bit registers are reached through a simple request port. A read strobe plus a register number returns the data on the next clock. A write strobe stores a word. Most registers are plain storage. Three are computed on every read from the stored advertisement word and a live link-status input: the basic status word, the link-partner ability word and a vendor diagnostic word. Because of this, the modelled link partner always reports the same abilities that were advertised, and the diagnostic word reports the best speed and duplex agreed between the two.

A MAC sits beside the block and watches a separate duplex output. That output is refreshed each time the diagnostic register is read, so the MAC can compare its own duplex setting with what the PHY settled on. The controller may place any value in the request field, but only its low five bits select a register.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset, register 0 holds 0x3100, register 2 holds 0x0300, register 3 holds 0xE400, register 4 (advertisement) holds 0x01E1, and every other stored register holds 0x0000.
- R2: `rd_valid_o` is high in exactly the cycle after a cycle with `rd_en_i` high. `rd_data_o` then holds the selected register's value and keeps it until the next read.
- R3: Register 1 reads 0x0000 while `link_up_i` is low. While the link is up it reads 0x782C, which is bits 14, 13, 12, 11, 5, 3 and 2 set.
- R4: Register 5 reads 0x4001 OR (register 4 AND 0x01E0), whatever the link state.
- R5: Register 18 reads 0x0000 while `link_up_i` is low.
- R6: With the link up, register 18 bit 10 is set when register 4 bit 7 or bit 8 is set. Otherwise it is clear.
- R7: With the link up, register 18 bit 11 is set when register 4 bit 6 or bit 8 is set. Otherwise it is clear. All other bits of register 18 are always clear.
- R8: Every register other than 1, 5 and 18 reads back the last word written to it. A write to register 1, 5 or 18 is accepted but leaves its read value computed.
- R9: Only bits [4:0] of `req_i` select the register, for reads and for writes. Higher request bits have no effect.
- R10: `duplex_o` is 0 after reset. It takes the value of register 18 bit 11 in the same cycle that the read data of a register-18 read appears, and `duplex_upd_o` pulses in that cycle. In all other cycles `duplex_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| link_up_i | input | 1 | Live link status, 1 = up |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe, never high together with `rd_en_i` |
| req_i | input | REQ_W (8) | Request; low 5 bits are the register number |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Registered read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after the strobe |
| duplex_o | output | 1 | Duplex result from the last diagnostic read |
| duplex_upd_o | output | 1 | Pulses when `duplex_o` was refreshed |

## Verification
Storage faults, such as a wrong reset word or a misdecoded write slot, appear on the first read of the affected register, one cycle after the strobe. So the bench reads all 32 registers straight after reset and again after writing a distinct word to each. Faults in the derived words are combinational in the advertisement word and the link input. They show on the very next read, so sweeping all 16 combinations of advertisement bits [8:5] under both link states reveals any wrong term. A stale or wrongly updated duplex flag appears in the cycle after a diagnostic read, or on a later read of another register when the flag should have held.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

   localparam int unsigned WORD_W = 16;

   // register indices whose behaviour the block depends on
   localparam int unsigned IDX_CTRL = 0;
   localparam int unsigned IDX_STAT = 1;
   localparam int unsigned IDX_ID_HI = 2;
   localparam int unsigned IDX_ID_LO = 3;
   localparam int unsigned IDX_ADV  = 4;
   localparam int unsigned IDX_LPA  = 5;
   localparam int unsigned IDX_DIAG = 18;

   // advertisement bit positions
   localparam int unsigned ADV_10F  = 6;
   localparam int unsigned ADV_100H = 7;
   localparam int unsigned ADV_100F = 8;

   // diagnostic bit positions
   localparam int unsigned DIAG_SPD = 10;
   localparam int unsigned DIAG_DPX = 11;

   localparam logic [WORD_W-1:0] STAT_LINK_UP = 16'h782C;
   localparam logic [WORD_W-1:0] LPA_FIXED    = 16'h4001;
   localparam logic [WORD_W-1:0] LPA_COPY     = 16'h01E0;

   function automatic logic [WORD_W-1:0] rst_word(input int unsigned idx);
      logic [WORD_W-1:0] w;
      case (idx)
         IDX_CTRL:  w = 16'h3100;
         IDX_ID_HI: w = 16'h0300;
         IDX_ID_LO: w = 16'hE400;
         IDX_ADV:   w = 16'h01E1;
         default:   w = '0;
      endcase
      return w;
   endfunction

   typedef enum logic [1:0] {
      SRC_STORE = 2'd0,
      SRC_STAT  = 2'd1,
      SRC_LPA   = 2'd2,
      SRC_DIAG  = 2'd3
   } rd_src_e;

endpackage

// File: rtl/phy_mgmt_store.sv
module phy_mgmt_store #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned REG_NUM = 32,
   localparam int unsigned ADDR_W = $clog2(REG_NUM)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_word_o,
   output logic [DATA_W-1:0] adv_o
);

   logic [REG_NUM-1:0][DATA_W-1:0] regs_q;

   for (genvar g = 0; g < REG_NUM; g++) begin : g_slot
      localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(phy_mgmt_pkg::rst_word(g));
      logic hit;
      assign hit = wr_en_i && (wr_addr_i == ADDR_W'(g));
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            regs_q[g] <= RST_VAL;
         end else if (hit) begin
            regs_q[g] <= wr_data_i;
         end
      end
   end

   assign rd_word_o = regs_q[rd_addr_i];
   assign adv_o     = regs_q[phy_mgmt_pkg::IDX_ADV];

endmodule

// File: rtl/phy_mgmt_derive.sv
module phy_mgmt_derive #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              link_up_i,
   input  logic [DATA_W-1:0] adv_i,
   output logic [DATA_W-1:0] stat_o,
   output logic [DATA_W-1:0] lpa_o,
   output logic [DATA_W-1:0] diag_o
);
   import phy_mgmt_pkg::*;

   logic spd_100;
   logic dpx_full;

   assign spd_100  = adv_i[ADV_100H] | adv_i[ADV_100F];
   assign dpx_full = adv_i[ADV_10F]  | adv_i[ADV_100F];

   assign stat_o = link_up_i ? STAT_LINK_UP : '0;
   assign lpa_o  = LPA_FIXED | (adv_i & LPA_COPY);

   always_comb begin
      diag_o = '0;
      if (link_up_i) begin
         diag_o[DIAG_SPD] = spd_100;
         diag_o[DIAG_DPX] = dpx_full;
      end
   end

endmodule

// File: rtl/phy_mgmt_rdport.sv
module phy_mgmt_rdport #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 5,
   parameter bit          DUPLEX_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic [DATA_W-1:0] store_i,
   input  logic [DATA_W-1:0] stat_i,
   input  logic [DATA_W-1:0] lpa_i,
   input  logic [DATA_W-1:0] diag_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o,
   output logic              duplex_o,
   output logic              duplex_upd_o
);
   import phy_mgmt_pkg::*;

   rd_src_e           src;
   logic [DATA_W-1:0] sel_word;
   logic              diag_hit;

   always_comb begin
      case (rd_addr_i)
         ADDR_W'(IDX_STAT): src = SRC_STAT;
         ADDR_W'(IDX_LPA):  src = SRC_LPA;
         ADDR_W'(IDX_DIAG): src = SRC_DIAG;
         default:           src = SRC_STORE;
      endcase
   end

   always_comb begin
      case (src)
         SRC_STAT: sel_word = stat_i;
         SRC_LPA:  sel_word = lpa_i;
         SRC_DIAG: sel_word = diag_i;
         default:  sel_word = store_i;
      endcase
   end

   assign diag_hit = rd_en_i && (src == SRC_DIAG);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_data_o  <= '0;
         rd_valid_o <= 1'b0;
      end else begin
         rd_valid_o <= rd_en_i;
         if (rd_en_i) begin
            rd_data_o <= sel_word;
         end
      end
   end

   if (DUPLEX_EN) begin : g_dpx
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            duplex_o     <= 1'b0;
            duplex_upd_o <= 1'b0;
         end else begin
            duplex_upd_o <= diag_hit;
            if (diag_hit) begin
               duplex_o <= diag_i[DIAG_DPX];
            end
         end
      end
   end else begin : g_no_dpx
      assign duplex_o     = 1'b0;
      assign duplex_upd_o = 1'b0;
   end

endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned REG_NUM   = 32,
   parameter int unsigned REQ_W     = 8,
   parameter bit          DUPLEX_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              link_up_i,
   input  logic              rd_en_i,
   input  logic              wr_en_i,
   input  logic [REQ_W-1:0]  req_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o,
   output logic              duplex_o,
   output logic              duplex_upd_o
);
   localparam int unsigned ADDR_W = $clog2(REG_NUM);

   if (DATA_W != phy_mgmt_pkg::WORD_W) begin : g_bad_width
      $error("phy_mgmt_regfile: DATA_W must equal 16");
   end
   if ((1 << ADDR_W) != REG_NUM || REG_NUM <= phy_mgmt_pkg::IDX_DIAG) begin : g_bad_depth
      $error("phy_mgmt_regfile: REG_NUM must be a power of two above 18");
   end
   if (REQ_W < ADDR_W) begin : g_bad_req
      $error("phy_mgmt_regfile: REQ_W narrower than register number");
   end

   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] store_word;
   logic [DATA_W-1:0] adv_word;
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] lpa_word;
   logic [DATA_W-1:0] diag_word;

   assign addr = req_i[ADDR_W-1:0];

   if (REQ_W > ADDR_W) begin : g_req_hi
      logic unused_req_hi;
      assign unused_req_hi = ^req_i[REQ_W-1:ADDR_W];
   end

   phy_mgmt_store #(
      .DATA_W (DATA_W),
      .REG_NUM(REG_NUM)
   ) i_store (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i),
      .wr_addr_i(addr),
      .wr_data_i(wr_data_i),
      .rd_addr_i(addr),
      .rd_word_o(store_word),
      .adv_o    (adv_word)
   );

   phy_mgmt_derive #(
      .DATA_W(DATA_W)
   ) i_derive (
      .link_up_i(link_up_i),
      .adv_i    (adv_word),
      .stat_o   (stat_word),
      .lpa_o    (lpa_word),
      .diag_o   (diag_word)
   );

   phy_mgmt_rdport #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .DUPLEX_EN(DUPLEX_EN)
   ) i_rdport (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rd_en_i     (rd_en_i),
      .rd_addr_i   (addr),
      .store_i     (store_word),
      .stat_i      (stat_word),
      .lpa_i       (lpa_word),
      .diag_i      (diag_word),
      .rd_data_o   (rd_data_o),
      .rd_valid_o  (rd_valid_o),
      .duplex_o    (duplex_o),
      .duplex_upd_o(duplex_upd_o)
   );

endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned REQ_W  = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              link_up_i,
   input logic              rd_en_i,
   input logic [REQ_W-1:0]  req_i,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              rd_valid_o,
   input logic              duplex_o
);
   logic is_stat, is_lpa, is_diag;
   assign is_stat = (req_i[4:0] == 5'd1);
   assign is_lpa  = (req_i[4:0] == 5'd5);
   assign is_diag = (req_i[4:0] == 5'd18);

   a_r2_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_i |=> rd_valid_o);
   a_r2_no_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> !rd_valid_o);
   a_r3_status_zero_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && is_stat && !link_up_i) |=> (rd_data_o == '0));
   a_r4_partner_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && is_lpa) |=> (rd_data_o[14] && rd_data_o[0]));
   a_r5_diag_zero_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && is_diag && !link_up_i) |=> (rd_data_o == '0));
   a_r10_duplex_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && is_diag) |=> (duplex_o == rd_data_o[11]));
   a_r10_duplex_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rd_en_i && is_diag) |=> $stable(duplex_o));

endmodule

bind phy_mgmt_regfile phy_mgmt_checker #(
   .DATA_W(DATA_W),
   .REQ_W (REQ_W)
) i_phy_mgmt_checker (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .link_up_i (link_up_i),
   .rd_en_i   (rd_en_i),
   .req_i     (req_i),
   .rd_data_o (rd_data_o),
   .rd_valid_o(rd_valid_o),
   .duplex_o  (duplex_o)
);

// File: tb/test_phy_mgmt_regfile.sv
module test_phy_mgmt_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        link = 1'b1;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  req = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        rvalid;
   logic        dpx;
   logic        dpx_upd;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   phy_mgmt_regfile i_phy_mgmt_regfile (
      .clk_i(clk), .rst_ni(rst_n), .link_up_i(link), .rd_en_i(rd_en),
      .wr_en_i(wr_en), .req_i(req), .wr_data_i(wdata), .rd_data_o(rdata),
      .rd_valid_o(rvalid), .duplex_o(dpx), .duplex_upd_o(dpx_upd)
   );

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
         finish_run();
      end
   end

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] r, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; req = r; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // read data and valid are sampled at the negedge after the capturing posedge
   task automatic rd(input logic [7:0] r, output logic [15:0] d);
      @(negedge clk);
      rd_en = 1'b1; req = r;
      @(negedge clk);
      rd_en = 1'b0;
      check("R2 valid", {15'd0, rvalid}, 16'd1);
      d = rdata;
   endtask

   function automatic logic [15:0] rst_exp(input int i);
      case (i)
         0: return 16'h3100;
         2: return 16'h0300;
         3: return 16'hE400;
         4: return 16'h01E1;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic logic [15:0] stat_exp(input logic l);
      return l ? 16'h782C : 16'h0000;
   endfunction

   function automatic logic [15:0] lpa_exp(input logic [15:0] a);
      return 16'h4001 | (a & 16'h01E0);
   endfunction

   function automatic logic [15:0] diag_exp(input logic [15:0] a, input logic l);
      logic [15:0] w;
      w = '0;
      if (l) begin
         w[10] = a[7] | a[8];
         w[11] = a[6] | a[8];
      end
      return w;
   endfunction

   function automatic bit derived(input int i);
      return (i == 1) || (i == 5) || (i == 18);
   endfunction

   function automatic logic [15:0] pat(input int i);
      return 16'hA55A ^ 16'(i * 16'h1357);
   endfunction

   initial begin
      logic [15:0] d;
      logic [15:0] adv;
      repeat (3) @(negedge clk);
      check("R1 reset valid low", {15'd0, rvalid}, 16'd0);
      check("R10 reset duplex", {15'd0, dpx}, 16'd0);
      rst_n = 1'b1;

      // R1: reset image of all registers (link up)
      for (int i = 0; i < 32; i++) begin
         rd(8'(i), d);
         if (i == 1)       check("R3 status after reset", d, 16'h782C);
         else if (i == 5)  check("R4 partner after reset", d, 16'h41E1);
         else if (i == 18) check("R6 R7 diag after reset", d, 16'h0C00);
         else              check($sformatf("R1 reset reg %0d", i), d, rst_exp(i));
      end
      check("R10 duplex after diag read", {15'd0, dpx}, 16'd1);

      // R2: data held while idle
      rd(8'd2, d);
      repeat (3) @(negedge clk);
      check("R2 data held", rdata, 16'h0300);
      check("R2 valid drops", {15'd0, rvalid}, 16'd0);

      // R8: write every register with a distinct word, keep reg 4 sane afterwards
      for (int i = 0; i < 32; i++) wr(8'(i), pat(i));
      for (int i = 0; i < 32; i++) begin
         rd(8'(i), d);
         adv = pat(4);
         if (i == 1)       check("R8 reg1 stays computed", d, stat_exp(1'b1));
         else if (i == 5)  check("R8 reg5 stays computed", d, lpa_exp(adv));
         else if (i == 18) check("R8 reg18 stays computed", d, diag_exp(adv, 1'b1));
         else              check($sformatf("R8 readback reg %0d", i), d, pat(i));
      end

      // R9: upper request bits ignored on write and read
      wr({3'b111, 5'd7}, 16'hBEEF);
      rd({3'b000, 5'd7}, d);
      check("R9 write alias", d, 16'hBEEF);
      rd({3'b101, 5'd7}, d);
      check("R9 read alias", d, 16'hBEEF);
      rd({3'b010, 5'd0}, d);
      check("R9 reg0 untouched", d, pat(0));

      // R3 R4 R5 R6 R7 R10: sweep advertisement bits [8:5] under both link states
      for (int l = 0; l < 2; l++) begin
         link = l[0];
         for (int a = 0; a < 16; a++) begin
            adv = 16'(a << 5) | ((a % 2 == 1) ? 16'h801F : 16'h7E01);
            wr(8'd4, adv);
            rd(8'd1, d);
            check("R3 status vs link", d, stat_exp(link));
            rd(8'd5, d);
            check("R4 partner ability", d, lpa_exp(adv));
            rd(8'd18, d);
            check(link ? "R6 R7 diag link up" : "R5 diag link down", d, diag_exp(adv, link));
            check("R10 duplex follows diag", {15'd0, dpx}, {15'd0, diag_exp(adv, link)[11]});
            // R10: other reads and link changes leave the flag alone
            link = ~link;
            rd(8'd4, d);
            check("R8 adv readback", d, adv);
            check("R10 duplex held", {15'd0, dpx}, {15'd0, diag_exp(adv, ~link)[11]});
            link = ~link;
         end
      end

      finish_run();
   end

endmodule